// File: doc/BRIEF.md
# Floating-Point Result Normalizer and Rounder

This block is the last stage of a single-precision floating-point datapath, shared by the add/subtract and multiply paths. It receives a raw significand with three extra low bits and a separate sticky input, a tentative biased exponent held as a signed number, the result sign, flags that mark the result as infinite or NaN, a flag that marks a signalling-NaN operand, and a 2-bit rounding mode. It normalizes the significand and exponent. When the exponent is too small, it produces a subnormal.

It then forms all four rounded significands at the same time and picks one by mode. It renormalizes when rounding carries out, handles overflow according to the mode, and packs the 32-bit result. The packed result and all status flags come from one output register, so they are valid one clock edge after the inputs are sampled.

Top module: `fp_post_norm`

## Requirements
- R1: The result and every flag are registered. Inputs sampled at a rising clock edge show up at the outputs after that edge, and not before it.
- R2: The significand `sig_i` carries weight 2 at bit 27 and weight 1 at bit 26. Bits 25:3 are the 23 fraction bits, bit 2 is guard, bit 1 is round and bit 0 joins the sticky. If bit 27 is set, the value shifts right one place and the exponent goes up by one. Otherwise leading zeros are shifted out and the exponent goes down to match, but the exponent is never taken below 1. A shift that is cut short this way leaves a subnormal, whose exponent field is 0.
- R3: When the normalized exponent is below 1, the significand shifts right by (1 - exponent) places and the exponent field becomes 0. Every bit shifted out goes into the sticky.
- R4: Rounding mode 00 (nearest even) adds one unit in the last place when guard is set and any of round, sticky or the kept LSB is set.
- R5: Rounding mode 01 (toward zero) truncates.
- R6: Rounding mode 10 (toward +infinity) adds one only to positive inexact results. Rounding mode 11 (toward -infinity) adds one only to negative inexact results.
- R7: A rounding carry out of the 24-bit significand shifts it right by one and raises the exponent by one. This also covers a subnormal that rounds up to the smallest normal.
- R8: `inexact_o` is set whenever any nonzero bit is dropped. This includes bits lost in the right shift of R2 and the `sticky_i` input.
- R9: An exponent of 255 or more after rounding raises `overflow_o` and `inexact_o`. The result is infinity in mode 00 and in the directed mode that points away from zero. In every other case the result is the largest finite value (exponent field 254, fraction all ones) with the result sign.
- R10: `underflow_o` is set when the packed result has exponent field 0 and is inexact.
- R11: `nan_i` gives the quiet NaN 0x7FC00000 with `qnan_o` set and all other flags clear. `snan_o` repeats `snan_i`.
- R12: `inf_i` gives a signed infinity with `inf_o` set. `zero_o` marks a packed result whose magnitude is zero, and keeps its sign.
- R13: An active-low `rst_n` clears the result and every flag at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sign_i | input | 1 | Sign of the result |
| exp_i | input | 10 | Tentative biased exponent, two's complement |
| sig_i | input | 28 | Raw significand with guard, round and sticky bits |
| sticky_i | input | 1 | OR of bits dropped before this stage |
| rmode_i | input | 2 | Rounding mode |
| inf_i | input | 1 | Result is infinity |
| nan_i | input | 1 | Result is NaN |
| snan_i | input | 1 | An operand was a signalling NaN |
| result_o | output | 32 | Packed single-precision result |
| inexact_o | output | 1 | Precision lost |
| overflow_o | output | 1 | Result too large |
| underflow_o | output | 1 | Tiny and inexact result |
| inf_o | output | 1 | Result is infinity |
| zero_o | output | 1 | Result is zero |
| qnan_o | output | 1 | Result is the quiet NaN |
| snan_o | output | 1 | Signalling-NaN operand seen |

## Verification
Every result and flag is due exactly one rising edge after its inputs are applied. The bench therefore drives on a falling edge and compares on the next falling edge, which comes after exactly one register update. One directed check samples the outputs before that edge and confirms they still hold the previous value. The reset check compares the outputs while `rst_n` is low, between clock edges, with no edge needed.

// File: rtl/fp_post_norm_pkg.sv
package fp_post_norm_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/pnr_lzc.sv
module pnr_lzc #(
  parameter int W  = 27,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) count_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/pnr_round_cands.sv
module pnr_round_cands
  import fp_post_norm_pkg::*;
#(
  parameter int MW = 24
) (
  input  logic [MW-1:0]     kept_i,
  input  logic              guard_i,
  input  logic              rnd_i,
  input  logic              stk_i,
  input  logic              sign_i,
  output logic [3:0][MW:0]  cand_o
);
  logic [MW:0] hold;
  logic [MW:0] bump;
  logic        lost;

  always_comb begin
    hold = {1'b0, kept_i};
    bump = hold + 1'b1;
    lost = guard_i | rnd_i | stk_i;
    cand_o[RND_NEAR] = (guard_i & (rnd_i | stk_i | kept_i[0])) ? bump : hold;
    cand_o[RND_ZERO] = hold;
    cand_o[RND_UP]   = (lost & ~sign_i) ? bump : hold;
    cand_o[RND_DOWN] = (lost & sign_i) ? bump : hold;
  end
endmodule

// File: rtl/fp_post_norm.sv
module fp_post_norm
  import fp_post_norm_pkg::*;
#(
  parameter int FRAC_W   = 23,
  parameter int EXP_BITS = 8,
  parameter int EXP_W    = 10,
  localparam int SIG_W   = FRAC_W + 5,
  localparam int OUT_W   = 1 + EXP_BITS + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic              sticky_i,
  input  logic [1:0]        rmode_i,
  input  logic              inf_i,
  input  logic              nan_i,
  input  logic              snan_i,
  output logic [OUT_W-1:0]  result_o,
  output logic              inexact_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              inf_o,
  output logic              zero_o,
  output logic              qnan_o,
  output logic              snan_o
);
  localparam int M_W    = SIG_W - 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int IW     = EXP_W + 2;
  localparam int LZ_W   = $clog2(M_W + 1);
  localparam logic signed [IW-1:0] ONE_S  = IW'(1);
  localparam logic signed [IW-1:0] MW_S   = IW'(M_W);
  localparam logic signed [IW-1:0] EMAX_S = IW'((1 << EXP_BITS) - 1);
  localparam logic [EXP_BITS-1:0]  EXP_ONES = '1;
  localparam logic [OUT_W-1:0] QNAN_W = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic signed [IW-1:0] e_in, e1, e2, e3, room, lz_s, rs;
  logic [M_W-1:0]       m1, m2;
  logic                 st1, st2;
  logic [LZ_W-1:0]      lz, shl, rsc;
  logic [MANT_W-1:0]    kept, mant;
  logic [3:0][MANT_W:0] cands;
  logic [MANT_W:0]      sel;
  logic                 g_b, r_b, s_b, inx, ovf, to_inf;
  logic [EXP_BITS-1:0]  efield;

  logic [OUT_W-1:0] res_d;
  logic inx_d, ovf_d, unf_d, inf_d, zero_d, qnan_d;

  // stage 1: fold a carry bit back into range
  always_comb begin
    e_in = $signed({{(IW-EXP_W){exp_i[EXP_W-1]}}, exp_i});
    if (sig_i[SIG_W-1]) begin
      m1  = sig_i[SIG_W-1:1];
      st1 = sig_i[0] | sticky_i;
      e1  = e_in + ONE_S;
    end else begin
      m1  = sig_i[M_W-1:0];
      st1 = sticky_i;
      e1  = e_in;
    end
  end

  pnr_lzc #(.W(M_W)) u_lzc (.vec_i(m1), .count_o(lz));

  // stage 2: left shift limited by exponent, or right shift into subnormal range
  always_comb begin
    lz_s = $signed({{(IW-LZ_W){1'b0}}, lz});
    room = e1 - ONE_S;
    rs   = ONE_S - e1;
    shl  = '0;
    rsc  = '0;
    if (e1 >= ONE_S) begin
      if (lz_s > room) begin
        shl = room[LZ_W-1:0];
        e2  = ONE_S;
      end else begin
        shl = lz;
        e2  = e1 - lz_s;
      end
      m2  = m1 << shl;
      st2 = st1;
    end else begin
      rsc = (rs > MW_S) ? LZ_W'(M_W) : rs[LZ_W-1:0];
      m2  = m1 >> rsc;
      st2 = st1 | ((m2 << rsc) != m1);
      e2  = ONE_S;
    end
    kept = m2[M_W-1:3];
    g_b  = m2[2];
    r_b  = m2[1];
    s_b  = m2[0] | st2;
    inx  = g_b | r_b | s_b;
  end

  pnr_round_cands #(.MW(MANT_W)) u_cands (
    .kept_i (kept),
    .guard_i(g_b),
    .rnd_i  (r_b),
    .stk_i  (s_b),
    .sign_i (sign_i),
    .cand_o (cands)
  );

  // stage 3: pick by mode, renormalize on carry, classify
  always_comb begin
    sel = cands[rmode_i];
    if (sel[MANT_W]) begin
      mant = sel[MANT_W:1];
      e3   = e2 + ONE_S;
    end else begin
      mant = sel[MANT_W-1:0];
      e3   = e2;
    end
    efield = mant[MANT_W-1] ? e3[EXP_BITS-1:0] : '0;
    ovf    = mant[MANT_W-1] && (e3 >= EMAX_S);
    to_inf = (rmode_i == RND_NEAR) || (rmode_i == RND_UP && !sign_i) ||
             (rmode_i == RND_DOWN && sign_i);

    res_d  = {sign_i, efield, mant[FRAC_W-1:0]};
    inx_d  = inx;
    ovf_d  = 1'b0;
    unf_d  = inx && (efield == '0);
    inf_d  = 1'b0;
    zero_d = (mant == '0);
    qnan_d = 1'b0;
    if (nan_i) begin
      res_d = QNAN_W;
      inx_d = 1'b0; unf_d = 1'b0; zero_d = 1'b0; qnan_d = 1'b1;
    end else if (inf_i) begin
      res_d = {sign_i, EXP_ONES, {FRAC_W{1'b0}}};
      inx_d = 1'b0; unf_d = 1'b0; zero_d = 1'b0; inf_d = 1'b1;
    end else if (ovf) begin
      inx_d  = 1'b1;
      ovf_d  = 1'b1;
      unf_d  = 1'b0;
      zero_d = 1'b0;
      inf_d  = to_inf;
      res_d  = to_inf ? {sign_i, EXP_ONES, {FRAC_W{1'b0}}}
                      : {sign_i, EXP_ONES - 1'b1, {FRAC_W{1'b1}}};
    end
  end

  // output register: breaks the long overflow/underflow path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o    <= '0;
      inexact_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inf_o       <= 1'b0;
      zero_o      <= 1'b0;
      qnan_o      <= 1'b0;
      snan_o      <= 1'b0;
    end else begin
      result_o    <= res_d;
      inexact_o   <= inx_d;
      overflow_o  <= ovf_d;
      underflow_o <= unf_d;
      inf_o       <= inf_d;
      zero_o      <= zero_d;
      qnan_o      <= qnan_d;
      snan_o      <= snan_i;
    end
  end
endmodule

// File: rtl/fp_post_norm_chk.sv
module fp_post_norm_chk #(
  parameter int FRAC_W   = 23,
  parameter int EXP_BITS = 8,
  localparam int OUT_W   = 1 + EXP_BITS + FRAC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sign_i,
  input logic             inf_i,
  input logic             nan_i,
  input logic             snan_i,
  input logic [OUT_W-1:0] result_o,
  input logic             inexact_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic             inf_o,
  input logic             zero_o,
  input logic             qnan_o,
  input logic             snan_o
);
  localparam logic [EXP_BITS-1:0] EONES = '1;
  localparam logic [OUT_W-1:0] QNAN_W = {1'b0, EONES, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [OUT_W-2:0] INF_M  = {EONES, {FRAC_W{1'b0}}};
  localparam logic [OUT_W-2:0] MAXF_M = {EONES - 1'b1, {FRAC_W{1'b1}}};

  AST_QNAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    qnan_o |-> result_o == QNAN_W); // R11
  AST_NAN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    nan_i |=> qnan_o); // R1
  AST_SNAN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    snan_i |=> snan_o); // R11
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inf_o, zero_o, qnan_o})); // R12
  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> result_o[OUT_W-2:0] == '0); // R12
  AST_INF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (inf_i && !nan_i) |=> inf_o && (result_o[OUT_W-1] == $past(sign_i))); // R12
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> inexact_o && (result_o[OUT_W-2:0] == INF_M ||
                                 result_o[OUT_W-2:0] == MAXF_M)); // R9
  AST_UNF_TINY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> inexact_o && result_o[OUT_W-2:FRAC_W] == '0); // R10
endmodule

bind fp_post_norm fp_post_norm_chk #(.FRAC_W(FRAC_W), .EXP_BITS(EXP_BITS)) u_chk (.*);

// File: tb/fp_post_norm_tb.sv
`timescale 1ns/1ps
module fp_post_norm_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sign_i;
  logic [9:0]  exp_i;
  logic [27:0] sig_i;
  logic        sticky_i;
  logic [1:0]  rmode_i;
  logic        inf_i, nan_i, snan_i;
  logic [31:0] result_o;
  logic        inexact_o, overflow_o, underflow_o, inf_o, zero_o, qnan_o, snan_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fp_post_norm u_dut (.*);

  // fields: sign, exp, sig, sticky, mode, {inf,nan,snan}, result,
  // flags {inexact,overflow,underflow,inf,zero,qnan,snan}, requirement
  localparam int NV = 33;
  localparam logic [91:0] VEC [NV] = '{
    {1'b0, 10'd127,  28'h4000000, 1'b0, 2'd0, 3'b000, 32'h3F800000, 7'b0000000, 8'd1 },  // R1
    {1'b0, 10'd127,  28'h8000000, 1'b0, 2'd0, 3'b000, 32'h40000000, 7'b0000000, 8'd2 },  // R2 carry bit
    {1'b0, 10'd129,  28'h1000000, 1'b0, 2'd0, 3'b000, 32'h3F800000, 7'b0000000, 8'd2 },  // R2 left shift
    {1'b0, 10'd3,    28'h0400000, 1'b0, 2'd0, 3'b000, 32'h00200000, 7'b0000000, 8'd2 },  // R2 limited
    {1'b0, 10'd1,    28'h0000008, 1'b0, 2'd0, 3'b000, 32'h00000001, 7'b0000000, 8'd2 },  // R2 no room
    {1'b0, 10'd127,  28'h4000004, 1'b0, 2'd0, 3'b000, 32'h3F800000, 7'b1000000, 8'd4 },  // R4 tie even
    {1'b0, 10'd127,  28'h400000C, 1'b0, 2'd0, 3'b000, 32'h3F800002, 7'b1000000, 8'd4 },  // R4 tie odd
    {1'b0, 10'd127,  28'h4000006, 1'b0, 2'd0, 3'b000, 32'h3F800001, 7'b1000000, 8'd4 },  // R4 above half
    {1'b0, 10'd127,  28'h400000C, 1'b0, 2'd1, 3'b000, 32'h3F800001, 7'b1000000, 8'd5 },  // R5
    {1'b1, 10'd127,  28'h400000E, 1'b0, 2'd1, 3'b000, 32'hBF800001, 7'b1000000, 8'd5 },  // R5 negative
    {1'b0, 10'd127,  28'h4000001, 1'b0, 2'd2, 3'b000, 32'h3F800001, 7'b1000000, 8'd6 },  // R6 up, pos
    {1'b0, 10'd127,  28'h4000001, 1'b0, 2'd3, 3'b000, 32'h3F800000, 7'b1000000, 8'd6 },  // R6 down, pos
    {1'b1, 10'd127,  28'h4000001, 1'b0, 2'd3, 3'b000, 32'hBF800001, 7'b1000000, 8'd6 },  // R6 down, neg
    {1'b1, 10'd127,  28'h4000001, 1'b0, 2'd2, 3'b000, 32'hBF800000, 7'b1000000, 8'd6 },  // R6 up, neg
    {1'b0, 10'd127,  28'h7FFFFFC, 1'b0, 2'd0, 3'b000, 32'h40000000, 7'b1000000, 8'd7 },  // R7 carry
    {1'b0, 10'd254,  28'h7FFFFFC, 1'b0, 2'd0, 3'b000, 32'h7F800000, 7'b1101000, 8'd7 },  // R7 into overflow
    {1'b0, 10'd255,  28'h4000000, 1'b0, 2'd0, 3'b000, 32'h7F800000, 7'b1101000, 8'd9 },  // R9 nearest
    {1'b0, 10'd255,  28'h4000000, 1'b0, 2'd1, 3'b000, 32'h7F7FFFFF, 7'b1100000, 8'd9 },  // R9 zero
    {1'b1, 10'd255,  28'h4000000, 1'b0, 2'd2, 3'b000, 32'hFF7FFFFF, 7'b1100000, 8'd9 },  // R9 up, neg
    {1'b1, 10'd255,  28'h4000000, 1'b0, 2'd3, 3'b000, 32'hFF800000, 7'b1101000, 8'd9 },  // R9 down, neg
    {1'b0, 10'd254,  28'h8000000, 1'b0, 2'd2, 3'b000, 32'h7F800000, 7'b1101000, 8'd9 },  // R9 up, pos
    {1'b0, 10'd0,    28'h4000000, 1'b0, 2'd0, 3'b000, 32'h00400000, 7'b0000000, 8'd3 },  // R3 exact
    {1'b0, 10'd0,    28'h4000008, 1'b0, 2'd0, 3'b000, 32'h00400000, 7'b1010000, 8'd10},  // R10
    {1'b0, 10'h3D8,  28'h4000000, 1'b0, 2'd1, 3'b000, 32'h00000000, 7'b1010100, 8'd10},  // R10 to zero
    {1'b0, 10'h3D8,  28'h4000000, 1'b0, 2'd2, 3'b000, 32'h00000001, 7'b1010000, 8'd3 },  // R3 all shifted out
    {1'b0, 10'd1,    28'h3FFFFFC, 1'b0, 2'd0, 3'b000, 32'h00800000, 7'b1000000, 8'd7 },  // R7 subnormal up
    {1'b0, 10'd127,  28'h4000000, 1'b1, 2'd2, 3'b000, 32'h3F800001, 7'b1000000, 8'd8 },  // R8 sticky_i
    {1'b0, 10'd127,  28'h8000001, 1'b0, 2'd2, 3'b000, 32'h40000001, 7'b1000000, 8'd8 },  // R8 shifted bit
    {1'b0, 10'd127,  28'h4000000, 1'b0, 2'd0, 3'b010, 32'h7FC00000, 7'b0000010, 8'd11},  // R11
    {1'b1, 10'd5,    28'h0000000, 1'b0, 2'd0, 3'b011, 32'h7FC00000, 7'b0000011, 8'd11},  // R11 snan
    {1'b1, 10'd127,  28'h4000000, 1'b0, 2'd0, 3'b100, 32'hFF800000, 7'b0001000, 8'd12},  // R12 inf
    {1'b1, 10'd100,  28'h0000000, 1'b0, 2'd0, 3'b000, 32'h80000000, 7'b0000100, 8'd12},  // R12 zero
    {1'b0, 10'd0,    28'h0000000, 1'b0, 2'd1, 3'b001, 32'h00000000, 7'b0000101, 8'd12}   // R12 zero+snan
  };

  function automatic logic [6:0] flags();
    return {inexact_o, overflow_o, underflow_o, inf_o, zero_o, qnan_o, snan_o};
  endfunction

  task automatic check(input logic [31:0] exp_res, input logic [6:0] exp_fl, input int req);
    n_run++;
    if (result_o !== exp_res || flags() !== exp_fl) begin
      n_fail++;
      $display("FAIL R%0d: result %h flags %b, expected %h flags %b",
               req, result_o, flags(), exp_res, exp_fl);
    end
  endtask

  task automatic drive(input logic [91:0] v);
    sign_i   = v[91];
    exp_i    = v[90:81];
    sig_i    = v[80:53];
    sticky_i = v[52];
    rmode_i  = v[51:50];
    {inf_i, nan_i, snan_i} = v[49:47];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(92'd0);
    #1;
    check(32'h0, 7'b0, 13);                 // R13 reset state
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check(VEC[i][46:15], VEC[i][14:8], int'(VEC[i][7:0]));
    end

    // R1: new input must not reach the outputs before the next rising edge
    @(negedge clk);
    drive(VEC[0]);
    @(negedge clk);
    drive(VEC[6]);
    #1;
    check(32'h3F800000, 7'b0, 1);           // R1 old value held
    @(negedge clk);
    check(32'h3F800002, 7'b1000000, 1);     // R1 new value after edge

    // R13: reset clears at once, between edges
    drive(VEC[16]);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check(32'h0, 7'b0, 13);                 // R13 asynchronous clear
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule